// File: doc/BRIEF.md
# Extended-Precision Zero-Test Flag Unit

This block takes one 80-bit extended-precision value from the top of a floating-point register stack, works out what kind of encoding it holds, and reports how it compares with zero. The answer is a three-bit condition pattern on C3, C2 and C0, with C1 always low. Three exception flags come with it: invalid operand, stack underflow and denormal source. An "unordered" outcome covers operands that cannot be compared at all.

A caller pulses `start` for one cycle while it presents the operand and the stack-empty tag. On the next clock edge the unit registers the result and raises `done` for exactly one cycle. The registered flags then stay unchanged until the next `start`. The stack itself, exception masking and trap delivery, and the merging of flags into a status word are all left to the surrounding logic.

The operand layout is fixed as follows:

- bit 79 is the sign;
- bits 78:64 are the biased exponent;
- bit 63 is the explicit integer bit;
- bits 62:0 are the fraction.

Top module: `fzt_zero_test`

## Requirements
- R1: A positive operand that is not a NaN and not unsupported gives C3,C2,C0 = 0,0,0. This covers normals, +infinity (exponent all ones, integer bit 1, fraction 0) and positive denormals.
- R2: A negative operand that is not a NaN and not unsupported gives C3,C2,C0 = 0,0,1. This covers normals, -infinity and negative denormals.
- R3: An operand with exponent 0 and bits 63:0 all zero gives C3,C2,C0 = 1,0,0 for either sign bit. No exception flag is raised.
- R4: An operand with exponent all ones, integer bit 1 and a nonzero fraction (a NaN) gives C3,C2,C0 = 1,1,1 and raises the invalid flag.
- R5: An operand with a nonzero exponent and integer bit 0 is unsupported. This includes unnormals, pseudo-NaNs and pseudo-infinities. It gives C3,C2,C0 = 1,1,1 and raises the invalid flag.
- R6: An operand with exponent 0 and bits 63:0 nonzero raises the denormal flag. Its condition bits then follow its sign, as in R1 and R2.
- R7: When the stack-empty tag is 1, the unit raises the underflow and invalid flags, forces C3,C2,C0 to 1,1,1 and keeps the denormal flag low, whatever the operand is.
- R8: C1 is 0 at all times.
- R9: `done` is high for exactly the one cycle after each cycle with `start` high. The result outputs change only on that edge and hold their value between starts.
- R10: A synchronous active-high reset drives `done`, all four condition bits and all three exception flags to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to test the operand |
| stack_empty | input | 1 | Tag bit: 1 when the stack top holds no value |
| operand | input | 80 | Extended-precision value at the stack top |
| done | output | 1 | One-cycle pulse marking a new result |
| cond_c0 | output | 1 | Condition bit C0 (1 when below zero or unordered) |
| cond_c1 | output | 1 | Condition bit C1, always 0 |
| cond_c2 | output | 1 | Condition bit C2 (1 only when unordered) |
| cond_c3 | output | 1 | Condition bit C3 (1 when equal to zero or unordered) |
| exc_invalid | output | 1 | Invalid operand: NaN, unsupported encoding or empty stack |
| exc_underflow | output | 1 | Stack underflow: empty stack top |
| exc_denormal | output | 1 | Denormal source operand |

## Verification
The operands are chosen to sit on each side of every classification edge, so that each decision in the unit is tested on both sides:

- signed zeros against the smallest denormals, which separates the equal result from a nonzero-by-sign result;
- pseudo-denormals against unnormals, which probes the integer bit at zero and at nonzero exponent;
- infinities against NaNs and pseudo-infinities, which probes the fraction and the integer bit at an all-ones exponent.

Each of these is also sent with the empty tag set, to show that underflow overrides both the ordering and the denormal flag. Back-to-back starts, idle gaps and a reset taken mid-stream cover the timing of `done`, the holding of results between starts, and clearing. A run of random operands with random tags completes the set, and every cycle is compared against a behavioural model.

// File: rtl/fzt_pkg.sv
package fzt_pkg;

   // Encoding classes for an extended-precision operand
   typedef enum logic [2:0] {
      FZT_ZERO   = 3'd0,
      FZT_DENORM = 3'd1,
      FZT_NORMAL = 3'd2,
      FZT_INF    = 3'd3,
      FZT_NAN    = 3'd4,
      FZT_UNSUP  = 3'd5
   } fzt_class_e;

   // Full result word carried from the encoder to the output register
   typedef struct packed {
      logic c3;
      logic c2;
      logic c1;
      logic c0;
      logic inv;
      logic und;
      logic den;
   } fzt_flags_t;

   localparam fzt_flags_t FZT_FLAGS_CLEAR = '0;

endpackage

// File: rtl/fzt_nz_detect.sv
// Wide nonzero detector built as lanes of OR reductions followed by a final OR.
module fzt_nz_detect #(
   parameter int W      = 63,
   parameter int LANE_W = 16
) (
   input  logic [W-1:0] vec,
   output logic         nonzero
);
   localparam int NLANES = (W + LANE_W - 1) / LANE_W;
   localparam int PAD_W  = NLANES * LANE_W;

   if (W < 1)      begin : g_chk_w    $error("fzt_nz_detect: W must be at least 1");      end
   if (LANE_W < 1) begin : g_chk_lane $error("fzt_nz_detect: LANE_W must be at least 1"); end

   logic [PAD_W-1:0]  padded;
   logic [NLANES-1:0] lane_any;

   assign padded = PAD_W'(vec);

   for (genvar i = 0; i < NLANES; i++) begin : g_lane
      assign lane_any[i] = |padded[i*LANE_W +: LANE_W];
   end

   assign nonzero = |lane_any;
endmodule

// File: rtl/fzt_classify.sv
// Splits the operand into fields and names its encoding class.
module fzt_classify
   import fzt_pkg::*;
#(
   parameter int EXP_W  = 15,
   parameter int MAN_W  = 64,
   parameter int LANE_W = 16,
   localparam int OP_W  = 1 + EXP_W + MAN_W
) (
   input  logic [OP_W-1:0] operand,
   output fzt_class_e      op_class,
   output logic            op_sign
);
   localparam int FRAC_W = MAN_W - 1;

   if (EXP_W < 2) begin : g_chk_exp $error("fzt_classify: EXP_W must be at least 2"); end
   if (MAN_W < 2) begin : g_chk_man $error("fzt_classify: MAN_W must be at least 2"); end

   logic [EXP_W-1:0]  exp_f;
   logic              int_bit;
   logic [FRAC_W-1:0] frac_f;
   logic              frac_nz;
   logic              exp_zero;
   logic              exp_ones;

   assign op_sign  = operand[OP_W-1];
   assign exp_f    = operand[OP_W-2 -: EXP_W];
   assign int_bit  = operand[MAN_W-1];
   assign frac_f   = operand[FRAC_W-1:0];
   assign exp_zero = (exp_f == '0);
   assign exp_ones = (exp_f == '1);

   fzt_nz_detect #(.W(FRAC_W), .LANE_W(LANE_W)) u_frac_nz (
      .vec     (frac_f),
      .nonzero (frac_nz)
   );

   always_comb begin
      if (exp_zero) begin
         // pseudo-denormals (integer bit set) are nonzero denormals too
         op_class = (int_bit || frac_nz) ? FZT_DENORM : FZT_ZERO;
      end else if (!int_bit) begin
         op_class = FZT_UNSUP;
      end else if (exp_ones) begin
         op_class = frac_nz ? FZT_NAN : FZT_INF;
      end else begin
         op_class = FZT_NORMAL;
      end
   end
endmodule

// File: rtl/fzt_encode.sv
// Maps class, sign and stack tag onto condition bits and exception flags.
module fzt_encode
   import fzt_pkg::*;
(
   input  fzt_class_e op_class,
   input  logic       op_sign,
   input  logic       empty,
   output fzt_flags_t flags
);
   always_comb begin
      flags = FZT_FLAGS_CLEAR;
      if (empty) begin
         {flags.c3, flags.c2, flags.c0} = 3'b111;
         flags.inv = 1'b1;
         flags.und = 1'b1;
      end else begin
         unique case (op_class)
            FZT_ZERO: begin
               flags.c3 = 1'b1;
            end
            FZT_NAN, FZT_UNSUP: begin
               {flags.c3, flags.c2, flags.c0} = 3'b111;
               flags.inv = 1'b1;
            end
            FZT_DENORM: begin
               flags.c0  = op_sign;
               flags.den = 1'b1;
            end
            default: begin
               flags.c0 = op_sign;
            end
         endcase
      end
   end
endmodule

// File: rtl/fzt_zero_test.sv
module fzt_zero_test
   import fzt_pkg::*;
#(
   parameter int EXP_W  = 15,
   parameter int MAN_W  = 64,
   parameter int LANE_W = 16,
   localparam int OP_W  = 1 + EXP_W + MAN_W
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            start,
   input  logic            stack_empty,
   input  logic [OP_W-1:0] operand,
   output logic            done,
   output logic            cond_c0,
   output logic            cond_c1,
   output logic            cond_c2,
   output logic            cond_c3,
   output logic            exc_invalid,
   output logic            exc_underflow,
   output logic            exc_denormal
);
   fzt_class_e op_class;
   logic       op_sign;
   fzt_flags_t next_flags;
   fzt_flags_t flags_q;
   logic       done_q;

   fzt_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W), .LANE_W(LANE_W)) u_class (
      .operand  (operand),
      .op_class (op_class),
      .op_sign  (op_sign)
   );

   fzt_encode u_enc (
      .op_class (op_class),
      .op_sign  (op_sign),
      .empty    (stack_empty),
      .flags    (next_flags)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         flags_q <= FZT_FLAGS_CLEAR;
         done_q  <= 1'b0;
      end else begin
         done_q <= start;
         if (start) flags_q <= next_flags;
      end
   end

   assign done          = done_q;
   assign cond_c3       = flags_q.c3;
   assign cond_c2       = flags_q.c2;
   assign cond_c1       = flags_q.c1;
   assign cond_c0       = flags_q.c0;
   assign exc_invalid   = flags_q.inv;
   assign exc_underflow = flags_q.und;
   assign exc_denormal  = flags_q.den;
endmodule

module fzt_zero_test_chk #(
   parameter int OP_W = 80
) (
   input logic            clk,
   input logic            rst,
   input logic            start,
   input logic            stack_empty,
   input logic [OP_W-1:0] operand,
   input logic            done,
   input logic            cond_c0,
   input logic            cond_c1,
   input logic            cond_c2,
   input logic            cond_c3,
   input logic            exc_invalid,
   input logic            exc_underflow,
   input logic            exc_denormal
);
   logic [6:0] outs;
   assign outs = {cond_c3, cond_c2, cond_c1, cond_c0, exc_invalid, exc_underflow, exc_denormal};

   assert_reset_clear_R10: assert property (@(posedge clk)
      rst |=> (outs == 7'd0 && !done));

   assert_done_follows_start_R9: assert property (@(posedge clk) disable iff (rst)
      start |=> done);

   assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (rst)
      !start |=> (!done && $stable(outs)));

   assert_c1_low_R8: assert property (@(posedge clk) disable iff (rst)
      !cond_c1);

   assert_zero_equal_R3: assert property (@(posedge clk) disable iff (rst)
      (start && !stack_empty && operand[OP_W-2:0] == '0)
      |=> (cond_c3 && !cond_c2 && !cond_c0 && !exc_invalid && !exc_denormal));

   assert_underflow_pattern_R7: assert property (@(posedge clk) disable iff (rst)
      (start && stack_empty)
      |=> (cond_c3 && cond_c2 && cond_c0 && exc_invalid && exc_underflow && !exc_denormal));

   assert_invalid_unordered_R4: assert property (@(posedge clk) disable iff (rst)
      exc_invalid |-> (cond_c3 && cond_c2 && cond_c0));

   assert_denormal_ordered_R6: assert property (@(posedge clk) disable iff (rst)
      exc_denormal |-> (!cond_c3 && !cond_c2 && !exc_invalid));
endmodule

bind fzt_zero_test fzt_zero_test_chk #(.OP_W(OP_W)) u_chk (
   .clk           (clk),
   .rst           (rst),
   .start         (start),
   .stack_empty   (stack_empty),
   .operand       (operand),
   .done          (done),
   .cond_c0       (cond_c0),
   .cond_c1       (cond_c1),
   .cond_c2       (cond_c2),
   .cond_c3       (cond_c3),
   .exc_invalid   (exc_invalid),
   .exc_underflow (exc_underflow),
   .exc_denormal  (exc_denormal)
);

// File: tb/sim_fzt_zero_test.sv
module sim_fzt_zero_test;
   localparam int CLK_PERIOD = 10;
   localparam int MAX_CYCLES = 200000;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        start = 1'b0;
   logic        stack_empty = 1'b0;
   logic [79:0] operand = '0;
   logic        done, c0, c1, c2, c3, inv, und, den;

   int n_checks = 0;
   int n_fail   = 0;
   string cur_tag = "R10";

   fzt_zero_test u0 (
      .clk(clk), .rst(rst), .start(start), .stack_empty(stack_empty),
      .operand(operand), .done(done),
      .cond_c0(c0), .cond_c1(c1), .cond_c2(c2), .cond_c3(c3),
      .exc_invalid(inv), .exc_underflow(und), .exc_denormal(den)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // expected {c3,c2,c1,c0,inv,und,den} from the requirements
   function automatic logic [6:0] ref_result(input logic [79:0] op, input logic emp);
      logic        s;
      int unsigned e;
      logic        ib;
      logic [62:0] fr;
      s  = op[79];
      e  = op[78:64];
      ib = op[63];
      fr = op[62:0];
      if (emp)                      return 7'b1101_110;   // R7
      if (e == 0 && !ib && fr == 0) return 7'b1000_000;   // R3
      if (e == 0)                   return {3'b000, s, 3'b001}; // R6
      if (!ib)                      return 7'b1101_100;   // R5
      if (e == 32767 && fr != 0)    return 7'b1101_100;   // R4
      return {3'b000, s, 3'b000};                         // R1/R2
   endfunction

   // behavioural model, advanced on the same edge as the design
   logic [6:0] m_flags = '0;
   logic       m_done  = 1'b0;
   string      m_tag   = "R10";
   logic       m_inrst = 1'b1;

   always @(posedge clk) begin
      m_inrst <= rst;
      if (rst) begin
         m_flags <= '0;
         m_done  <= 1'b0;
         m_tag   <= "R10";
      end else begin
         m_done <= start;
         if (start) begin
            m_flags <= ref_result(operand, stack_empty);
            m_tag   <= cur_tag;
         end
      end
   end

   task automatic chk(input string name, input string tag, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, name, act, exp, $time);
      end
   endtask

   // compare every clock, away from the rising edge
   always @(negedge clk) begin
      string t;
      t = m_inrst ? "R10" : m_tag;
      chk("done", m_inrst ? "R10" : "R9", done, m_done);
      chk("c1",   m_inrst ? "R10" : "R8", c1, m_flags[4]);
      chk("c3", t, c3, m_flags[6]);
      chk("c2", t, c2, m_flags[5]);
      chk("c0", t, c0, m_flags[3]);
      chk("invalid", t, inv, m_flags[2]);
      chk("underflow", t, und, m_flags[1]);
      chk("denormal", t, den, m_flags[0]);
   end

   task automatic send(input logic [79:0] op, input logic emp, input string tag);
      @(negedge clk); #1;
      start = 1'b1; operand = op; stack_empty = emp; cur_tag = tag;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); #1;
         start = 1'b0; operand = {$urandom, $urandom, $urandom}; stack_empty = $urandom;
      end
   endtask

   function automatic logic [79:0] mk(input logic s, input logic [14:0] e, input logic [63:0] m);
      return {s, e, m};
   endfunction

   initial begin
      #(CLK_PERIOD * MAX_CYCLES);
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      #1 rst = 1'b0;
      idle(2);
      send(mk(0, 15'h3FFF, 64'h8000_0000_0000_0000), 0, "R1");  // +1.0
      send(mk(1, 15'h4000, 64'hA000_0000_0000_0000), 0, "R2");  // -2.5
      idle(3);                                                  // hold, R9
      send(mk(0, 15'h0000, 64'h0), 0, "R3");                    // +0
      idle(1);
      send(mk(1, 15'h0000, 64'h0), 0, "R3");                    // -0
      send(mk(0, 15'h7FFF, 64'h8000_0000_0000_0000), 0, "R1");  // +inf
      send(mk(1, 15'h7FFF, 64'h8000_0000_0000_0000), 0, "R2");  // -inf
      send(mk(0, 15'h7FFF, 64'hC000_0000_0000_0000), 0, "R4");  // quiet NaN
      send(mk(1, 15'h7FFF, 64'h8000_0000_0000_0001), 0, "R4");  // signaling NaN
      send(mk(0, 15'h1234, 64'h4000_0000_0000_0000), 0, "R5");  // unnormal
      send(mk(0, 15'h7FFF, 64'h0), 0, "R5");                    // pseudo-infinity
      send(mk(1, 15'h7FFF, 64'h4000_0000_0000_0000), 0, "R5");  // pseudo-NaN
      send(mk(0, 15'h0000, 64'h1), 0, "R6");                    // smallest +denormal
      send(mk(1, 15'h0000, 64'h1), 0, "R6");                    // smallest -denormal
      send(mk(1, 15'h0000, 64'h8000_0000_0000_0000), 0, "R6");  // pseudo-denormal
      send(mk(0, 15'h0001, 64'h8000_0000_0000_0000), 0, "R1");  // smallest normal
      send(mk(0, 15'h0000, 64'h1), 1, "R7");                    // empty, denormal bits
      send(mk(0, 15'h3FFF, 64'h8000_0000_0000_0000), 1, "R7");  // empty, normal bits
      send(mk(1, 15'h0000, 64'h0), 1, "R7");                    // empty, zero bits
      idle(2);
      send(mk(1, 15'h2000, 64'hFFFF_0000_0000_0000), 0, "R2");
      @(negedge clk); #1 start = 1'b0; rst = 1'b1;               // mid-run reset
      @(negedge clk); #1 rst = 1'b0;
      idle(2);
      for (int k = 0; k < 400; k++) begin
         logic [79:0] r;
         logic        re;
         r  = {$urandom, $urandom, $urandom};
         case (k % 4)
            0: r[78:64] = 15'h0000;
            1: r[78:64] = 15'h7FFF;
            default: ;
         endcase
         re = ($urandom % 5) == 0;
         send(r, re, re ? "R7" : (r[78:64] == 0 ? "R6" : (r[63] ? "R1" : "R5")));
         if ($urandom % 3 == 0) idle(1);
      end
      idle(3);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end
endmodule